// File: doc/BRIEF.md
# Cascaded integrator-comb decimator

This block lowers the sample rate of a signed stream by a fixed factor while low-pass filtering it, using only adders, subtractors and registers. A chain of N running-sum stages accumulates every accepted input sample. A phase counter keeps one result in every R. A chain of N differencing stages then processes the kept results at the reduced rate and produces one output word per R accepted inputs.

The comb delay is 1 or 2 low-rate samples and can be chosen at run time. When the choice changes, the comb history is cleared. The running sums use wide registers and wrap freely in two's complement; the final differences are still exact. A bypass input turns the block into a one-cycle pass-through of the input stream. The filter keeps running behind the pass-through, so leaving bypass gives correct filtered output at once.

Top module: `cic_decimator`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_data` are 0, and the decimation phase is 0. The first filtered output follows the R-th accepted input after reset.
- R2: With bypass low, each filtered output equals the N-fold cascade of length-(R·M) boxcar sums of the input, evaluated at every R-th accepted input. The input is taken as zero before reset.
- R3: With bypass low, `out_valid` is high for exactly one cycle, in the cycle after every R-th accepted input, and at no other time.
- R4: A constant input c gives a steady output of c·(R·M)^N scaled by 2^-(W_ACC-W_OUT). With the defaults and c = 256, this is 512 for M = 1 and 4096 for M = 2.
- R5: `diff_sel` = 0 selects comb delay M = 1, and `diff_sel` = 1 selects M = 2.
- R6: On any clock edge where `diff_sel` differs from its value at the previous edge, every comb history register is cleared. A sample kept at that edge uses zero history.
- R7: The internal width is W_ACC = W_IN + N·clog2(2R). Running sums wrap modulo 2^W_ACC, and full-scale inputs still give exact outputs.
- R8: With bypass high, `out_valid` equals the previous cycle's `in_valid`, and `out_data` equals the previous cycle's `in_data` sign-extended to W_OUT.
- R9: Accepted inputs during bypass still advance the running sums, the phase and the comb history. The filtered outputs after bypass ends match a filter that never stopped.
- R10: `out_data` is bits [W_ACC-1 : W_ACC-W_OUT] of the last comb result, which is the floor of the result divided by 2^(W_ACC-W_OUT).
- R11: A cycle with `in_valid` low changes neither the running sums nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | 1: pass input straight through; 0: filtered output |
| diff_sel | input | 1 | Comb delay select: 0 gives M=1, 1 gives M=2 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W_IN | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | W_OUT | Signed output sample |

## Verification
The embedded assertions check the per-cycle rules on every cycle: the phase stays in range, kept samples never fall in adjacent cycles, no output strobe appears without an input strobe in the cycle before, the bypass path copies strobe and sign-extended data, and a change of delay select leaves the comb history at zero. The arithmetic itself can only be shown by the bench scenarios. These cover impulse, step, random data with gaps, full-scale wrap-around, switching the delay mid-stream and returning from bypass. Each output is compared against a behavioural model built on modular running sums and differences, and the steady DC gains are compared with their closed-form values.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Comb differential delay selection
    typedef enum logic {
        DLY_ONE = 1'b0,
        DLY_TWO = 1'b1
    } diff_dly_e;

    localparam int unsigned MAX_DIFF_DLY = 2;

    // Per-edge control for the low-rate section
    typedef struct packed {
        logic      keep;
        logic      flush;
        diff_dly_e dly;
    } comb_ctrl_t;

    // Register growth needed for full precision at the largest delay
    function automatic int unsigned growth_bits(input int unsigned stages,
                                                input int unsigned rate);
        return stages * $clog2(rate * MAX_DIFF_DLY);
    endfunction

endpackage

// File: rtl/cic_integrators.sv
module cic_integrators #(
    parameter int unsigned W_IN   = 16,
    parameter int unsigned W_ACC  = 28,
    parameter int unsigned STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [W_IN-1:0]   x,
    output logic [W_ACC-1:0]  last_sum
);
    localparam int unsigned EXT = W_ACC - W_IN;

    logic [W_ACC-1:0] acc  [STAGES];
    logic [W_ACC-1:0] link [STAGES+1];

    assign link[0] = {{EXT{x[W_IN-1]}}, x};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Running sum: new value is old sum plus the new value of the stage before
        assign link[g+1] = acc[g] + link[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                acc[g] <= '0;
            end else if (en) begin
                acc[g] <= link[g+1];
            end
        end

        // R11: an idle cycle leaves every running sum untouched
        a_r11_idle_holds_sum: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(acc[g]));
    end

    assign last_sum = link[STAGES];

endmodule

// File: rtl/cic_phase.sv
module cic_phase #(
    parameter int unsigned RATE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic keep
);
    localparam int unsigned PW = (RATE > 1) ? $clog2(RATE) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATE - 1);

    logic [PW-1:0] phase;

    assign keep = en && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (en) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // R3: the phase never leaves the range 0..RATE-1
    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    if (RATE > 1) begin : g_spacing
        // R3: two kept samples never fall in adjacent cycles
        a_r3_keep_spacing: assert property (@(posedge clk) disable iff (rst)
            keep |=> !keep);
    end

endmodule

// File: rtl/cic_combs.sv
module cic_combs
    import cic_pkg::*;
#(
    parameter int unsigned W_ACC  = 28,
    parameter int unsigned STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  comb_ctrl_t        ctrl,
    input  logic [W_ACC-1:0]  x,
    output logic [W_ACC-1:0]  y
);
    logic [W_ACC-1:0] link [STAGES+1];

    assign link[0] = x;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W_ACC-1:0] hist1;
        logic [W_ACC-1:0] hist2;
        logic [W_ACC-1:0] hist1_eff;
        logic [W_ACC-1:0] hist2_eff;
        logic [W_ACC-1:0] sub;

        // A delay change is seen as empty history in the same cycle
        assign hist1_eff = ctrl.flush ? '0 : hist1;
        assign hist2_eff = ctrl.flush ? '0 : hist2;
        assign sub       = (ctrl.dly == DLY_TWO) ? hist2_eff : hist1_eff;
        assign link[g+1] = link[g] - sub;

        always_ff @(posedge clk) begin
            if (rst) begin
                hist1 <= '0;
                hist2 <= '0;
            end else if (ctrl.keep) begin
                hist1 <= link[g];
                hist2 <= hist1_eff;
            end else if (ctrl.flush) begin
                hist1 <= '0;
                hist2 <= '0;
            end
        end

        // R6: a delay change without a kept sample leaves the history empty
        a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
            ctrl.flush && !ctrl.keep |=> (hist1 == '0) && (hist2 == '0));

        // R6: a kept sample at a delay change enters with an empty older slot
        a_r6_flush_keep_older_empty: assert property (@(posedge clk) disable iff (rst)
            ctrl.flush && ctrl.keep |=> (hist2 == '0));
    end

    assign y = link[STAGES];

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
    import cic_pkg::*;
#(
    parameter int unsigned W_IN  = 16,
    parameter int unsigned W_OUT = 20,
    parameter int unsigned N     = 3,
    parameter int unsigned R     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              diff_sel,
    input  logic              in_valid,
    input  logic [W_IN-1:0]   in_data,
    output logic              out_valid,
    output logic [W_OUT-1:0]  out_data
);
    localparam int unsigned W_ACC = W_IN + growth_bits(N, R);
    localparam int unsigned BEXT  = W_OUT - W_IN;

    diff_dly_e        dly_now;
    diff_dly_e        dly_q;
    logic             keep;
    logic [W_ACC-1:0] int_out;
    logic [W_ACC-1:0] comb_out;
    logic [W_OUT-1:0] pass_word;
    comb_ctrl_t       ctrl;

    assign dly_now   = diff_dly_e'(diff_sel);
    assign pass_word = {{BEXT{in_data[W_IN-1]}}, in_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= DLY_ONE;
        end else begin
            dly_q <= dly_now;
        end
    end

    always_comb begin
        ctrl.keep  = keep;
        ctrl.flush = (dly_now != dly_q);
        ctrl.dly   = dly_now;
    end

    cic_integrators #(
        .W_IN   (W_IN),
        .W_ACC  (W_ACC),
        .STAGES (N)
    ) u_int (
        .clk      (clk),
        .rst      (rst),
        .en       (in_valid),
        .x        (in_data),
        .last_sum (int_out)
    );

    cic_phase #(
        .RATE (R)
    ) u_phase (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .keep (keep)
    );

    cic_combs #(
        .W_ACC  (W_ACC),
        .STAGES (N)
    ) u_comb (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .x    (int_out),
        .y    (comb_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (bypass) begin
            out_valid <= in_valid;
            out_data  <= pass_word;
        end else begin
            out_valid <= keep;
            if (keep) begin
                out_data <= comb_out[W_ACC-1 -: W_OUT];
            end
        end
    end

    // R8: in bypass the strobe is the input strobe one cycle later
    a_r8_bypass_strobe: assert property (@(posedge clk) disable iff (rst)
        bypass |=> out_valid == $past(in_valid));

    // R8: in bypass the word is the sign-extended input one cycle later
    a_r8_bypass_word: assert property (@(posedge clk) disable iff (rst)
        bypass && in_valid |=> out_data == {{BEXT{$past(in_data[W_IN-1])}}, $past(in_data)});

    // R3: no output strobe without an accepted input in the cycle before
    a_r3_strobe_needs_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R11: an idle input cycle is never followed by a filtered strobe
    a_r11_idle_no_output: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !bypass |=> !out_valid);

endmodule

// File: tb/cic_decimator_test.sv
module cic_decimator_test;
    localparam int W_IN  = 16;
    localparam int W_OUT = 20;
    localparam int N     = 3;
    localparam int R     = 8;
    localparam int W_ACC = W_IN + N * 4;
    localparam int SHIFT = W_ACC - W_OUT;

    logic              clk = 1'b0;
    logic              rst;
    logic              bypass;
    logic              diff_sel;
    logic              in_valid;
    logic [W_IN-1:0]   in_data;
    logic              out_valid;
    logic [W_OUT-1:0]  out_data;

    always #2 clk = ~clk;

    cic_decimator #(.W_IN(W_IN), .W_OUT(W_OUT), .N(N), .R(R)) uut (
        .clk(clk), .rst(rst), .bypass(bypass), .diff_sel(diff_sel),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 0;
    longint last_word = 0;

    // Behavioural reference: modular running sums, rate drop, modular differences
    longint sums [N];
    longint h1 [N];
    longint h2 [N];
    int     ph;
    bit     sel_q;
    localparam longint MASK = (longint'(1) <<< W_ACC) - 1;

    function automatic longint to_signed(input longint v);
        longint m = v & MASK;
        if (((m >>> (W_ACC - 1)) & 1) != 0) return m - (longint'(1) <<< W_ACC);
        return m;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < N; k++) begin
            sums[k] = 0; h1[k] = 0; h2[k] = 0;
        end
        ph = 0;
        sel_q = 0;
    endtask

    task automatic step(input bit v, input longint x, input bit byp, input bit sel,
                        input string req);
        bit     keep;
        bit     ev;
        longint ed;
        longint res;
        longint cur;
        @(negedge clk);
        in_valid = v;
        in_data  = W_IN'(x);
        bypass   = byp;
        diff_sel = sel;
        keep = 0;
        res  = 0;
        if (v) begin
            cur = x;
            for (int k = 0; k < N; k++) begin
                sums[k] = (sums[k] + cur) & MASK;
                cur = sums[k];
            end
            keep = (ph == R - 1);
            ph = keep ? 0 : ph + 1;
        end
        if (sel != sel_q) begin
            for (int k = 0; k < N; k++) begin
                h1[k] = 0; h2[k] = 0;
            end
        end
        sel_q = sel;
        if (keep) begin
            cur = sums[N-1];
            for (int k = 0; k < N; k++) begin
                longint d;
                d = (cur - (sel ? h2[k] : h1[k])) & MASK;
                h2[k] = h1[k];
                h1[k] = cur;
                cur = d;
            end
            res = to_signed(cur) >>> SHIFT;
        end
        ev = byp ? v : keep;
        ed = byp ? x : res;
        @(posedge clk);
        #1;
        check({req, " strobe"}, longint'(out_valid), longint'(ev));
        if (ev && out_valid) begin
            check({req, " data"}, longint'($signed(out_data)), ed);
            last_word = longint'($signed(out_data));
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; bypass = 0; diff_sel = 0; in_valid = 0; in_data = '0;
        model_clear();
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset strobe", longint'(out_valid), 0);
        check("R1 reset data", longint'($signed(out_data)), 0);
        @(negedge clk);
        rst = 0;

        // R1/R2: impulse, first output after the R-th input
        step(1, 16384, 0, 0, "R1");
        for (int i = 0; i < 47; i++) step(1, 0, 0, 0, "R2");

        // R10: small negative impulse exercises floor truncation
        step(1, -300, 0, 0, "R10");
        for (int i = 0; i < 39; i++) step(1, 0, 0, 0, "R10");

        // R4: DC gain with M = 1
        for (int i = 0; i < 64; i++) step(1, 256, 0, 0, "R4");
        check("R4 dc gain M=1", last_word, 512);

        // R6: delay change in an idle cycle, then R5: M = 2 gain
        step(0, 0, 0, 1, "R6");
        for (int i = 0; i < 64; i++) step(1, 256, 0, 1, "R5");
        check("R5 dc gain M=2", last_word, 4096);

        // R7: full-scale inputs wrap the running sums
        for (int i = 0; i < 80; i++) step(1, 32767, 0, 1, "R7");
        check("R7 full scale positive", last_word, 524272);
        for (int i = 0; i < 80; i++) step(1, -32768, 0, 1, "R7");
        check("R7 full scale negative", last_word, -524288);

        // R3/R11: random data with idle gaps
        for (int i = 0; i < 400; i++) begin
            bit v = ($urandom_range(0, 9) < 7);
            longint x = longint'($urandom_range(0, 65535)) - 32768;
            step(v, x, 0, 1, (v ? "R3" : "R11"));
        end

        // R6: delay changes while streaming, including at kept samples
        for (int i = 0; i < 200; i++) begin
            bit s = ((i / 13) % 2) == 1;
            longint x = longint'($urandom_range(0, 4095)) - 2048;
            step(1, x, 0, s, "R6");
        end

        // R8: bypass with gaps
        for (int i = 0; i < 60; i++) begin
            bit v = ($urandom_range(0, 3) != 0);
            longint x = longint'($urandom_range(0, 65535)) - 32768;
            step(v, x, 1, 0, "R8");
        end

        // R9: filter continued behind bypass
        for (int i = 0; i < 120; i++) begin
            longint x = longint'($urandom_range(0, 65535)) - 32768;
            step(1, x, 0, 0, "R9");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule